// File: doc/BRIEF.md
# Buffered timer clock prescaler

This block divides the system clock for a basic up-counting timer. A programmed ratio N makes it raise a one-cycle counter-clock-enable pulse once in every N+1 enabled clock cycles. Ratios run from 0 to 65535, so the division factor runs from 1 to 65536. Software writes the ratio into a preload register at any time. The divider uses a separate shadow copy, and the shadow copy changes only when the timer signals an update event. A write made partway through a period therefore never shortens or stretches that period.

A small auto-reload up-counter is included so that update events arise from the block's own counting. The counter advances once per divider pulse. On the pulse that finds it at its reload value, the counter returns to zero and raises the update event. At that event the shadow ratio is reloaded and the divider restarts from zero. A software update request produces the same effect at once, whether or not counting is enabled.

The divider and the counter are each built around a classified event. The divider's events are HOLD (disabled), STEP (advance), WRAP (limit reached, pulse, return to zero) and FORCE (software restart). The counter's events are HOLD (no pulse), INC, WRAP (reload value reached, update event) and CLEAR (software restart).

Top module: `tmr_psc_top`

## Requirements
- R1: Reset clears the preload ratio, the shadow ratio, the divider position and the timer counter to 0, and sets the reload value to the parameter ARR_INIT (all ones by default). Right after reset, an enabled block therefore pulses `tick` on every cycle and `cnt_val` counts 0, 1, 2, ...
- R2: With shadow ratio N, the divider position steps 0..N over enabled cycles. `tick` is high in the cycle where the position equals N, and the position returns to 0 at that edge, giving exactly one pulse per N+1 enabled cycles for every N from 0 to 65535.
- R3: While `cnt_en` is low and no software update is requested, `tick` stays low and the divider position and `cnt_val` hold their values. Counting resumes from the held position.
- R4: `cnt_val` increases by one at each edge where `tick` is high. When `tick` is high and `cnt_val` equals the reload value, `upd_evt` is high in that same cycle and `cnt_val` becomes 0 at the edge.
- R5: A prescaler write (`psc_wr_en`) changes only the preload register. The period in progress, and every later period, keeps the old ratio until an update event occurs.
- R6: At every update event, the shadow ratio takes the preload value and the divider position restarts at 0. The first pulse at the new ratio N arrives in the (N+1)th enabled cycle after the event.
- R7: When `sw_upd` is high, `upd_evt` is high and `tick` is low in that cycle, whatever the state of `cnt_en`. At the edge, the divider position and `cnt_val` clear to 0 and the shadow ratio is loaded.
- R8: A reload write (`arr_wr_en`) is not buffered. The written value is the compare value from the following cycle onward.
- R9: When a prescaler write and an update event fall in the same cycle, the shadow takes the preload value held before that edge. The newly written value waits for the next update event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_wr_en | input | 1 | Write strobe for the preload ratio |
| psc_wr_data | input | 16 | Ratio value N (divides by N+1) |
| arr_wr_en | input | 1 | Write strobe for the reload value |
| arr_wr_data | input | 16 | Reload (compare) value of the timer counter |
| cnt_en | input | 1 | Counting enable for the divider and the counter |
| sw_upd | input | 1 | Software update request |
| tick | output | 1 | One-cycle counter-clock-enable pulse |
| cnt_val | output | 16 | Timer counter value |
| upd_evt | output | 1 | One-cycle update event (overflow or software request) |

## Verification
On every cycle, the assertions check the following relations between the ports. A pulse never appears while disabled or during a software request. The counter holds when idle and steps by exactly one per pulse. An update event always clears the counter. A natural update event only occurs together with a pulse.

The exact spacing of pulses for each ratio, the restart phase after an update, and the deferral of a ratio write depend on the programmed values over many cycles. The same holds for the same-cycle write and update ordering and the immediate reload write. These are shown only by the bench's sweeps and scenarios, which compare against positions computed arithmetically from the cycle index.

// File: rtl/tmr_psc_pkg.sv
package tmr_psc_pkg;

    // Divider event classification for one cycle
    typedef enum logic [1:0] {
        PS_HOLD  = 2'd0,
        PS_STEP  = 2'd1,
        PS_WRAP  = 2'd2,
        PS_FORCE = 2'd3
    } psc_ev_e;

    // Timer counter event classification for one cycle
    typedef enum logic [1:0] {
        CT_HOLD  = 2'd0,
        CT_INC   = 2'd1,
        CT_WRAP  = 2'd2,
        CT_CLEAR = 2'd3
    } cnt_ev_e;

endpackage

// File: rtl/tmr_psc_regs.sv
module tmr_psc_regs #(
    parameter int unsigned PW = 16,
    parameter int unsigned CW = 16,
    parameter logic [CW-1:0] ARR_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psc_wr_en,
    input  logic [PW-1:0] psc_wr_data,
    input  logic          arr_wr_en,
    input  logic [CW-1:0] arr_wr_data,
    input  logic          upd,
    output logic [PW-1:0] ratio,
    output logic [CW-1:0] reload
);

    logic [PW-1:0] preload_q;
    logic [PW-1:0] shadow_q;
    logic [CW-1:0] reload_q;

    // Preload: written by software at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (psc_wr_en) begin
            preload_q <= psc_wr_data;
        end
    end

    // Shadow: copies the value held in preload before this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (upd) begin
            shadow_q <= preload_q;
        end
    end

    // Reload value: unbuffered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= ARR_INIT;
        end else if (arr_wr_en) begin
            reload_q <= arr_wr_data;
        end
    end

    assign ratio  = shadow_q;
    assign reload = reload_q;

endmodule

// File: rtl/tmr_psc_div.sv
module tmr_psc_div
    import tmr_psc_pkg::*;
#(
    parameter int unsigned PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          restart,
    input  logic [PW-1:0] ratio,
    output logic          tick
);

    localparam logic [PW-1:0] STEP_ONE = PW'(1);

    logic [PW-1:0] pos_q;
    psc_ev_e       ev;

    // Event decode
    always_comb begin
        if (restart) begin
            ev = PS_FORCE;
        end else if (!en) begin
            ev = PS_HOLD;
        end else if (pos_q == ratio) begin
            ev = PS_WRAP;
        end else begin
            ev = PS_STEP;
        end
    end

    // Position register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            unique case (ev)
                PS_HOLD:  pos_q <= pos_q;
                PS_STEP:  pos_q <= pos_q + STEP_ONE;
                PS_WRAP:  pos_q <= '0;
                PS_FORCE: pos_q <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (ev)
            PS_WRAP: tick = 1'b1;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_psc_cnt.sv
module tmr_psc_cnt
    import tmr_psc_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          ovf
);

    localparam logic [CW-1:0] INC_ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    cnt_ev_e       ev;

    // Event decode
    always_comb begin
        if (clear) begin
            ev = CT_CLEAR;
        end else if (!tick) begin
            ev = CT_HOLD;
        end else if (cnt_q == reload) begin
            ev = CT_WRAP;
        end else begin
            ev = CT_INC;
        end
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (ev)
                CT_HOLD:  cnt_q <= cnt_q;
                CT_INC:   cnt_q <= cnt_q + INC_ONE;
                CT_WRAP:  cnt_q <= '0;
                CT_CLEAR: cnt_q <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        unique case (ev)
            CT_WRAP: ovf = 1'b1;
            default: ovf = 1'b0;
        endcase
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_psc_top.sv
module tmr_psc_top #(
    parameter int unsigned PW = 16,
    parameter int unsigned CW = 16,
    parameter logic [CW-1:0] ARR_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psc_wr_en,
    input  logic [PW-1:0] psc_wr_data,
    input  logic          arr_wr_en,
    input  logic [CW-1:0] arr_wr_data,
    input  logic          cnt_en,
    input  logic          sw_upd,
    output logic          tick,
    output logic [CW-1:0] cnt_val,
    output logic          upd_evt
);

    logic [PW-1:0] ratio;
    logic [CW-1:0] reload;
    logic          ovf;

    tmr_psc_regs #(
        .PW       (PW),
        .CW       (CW),
        .ARR_INIT (ARR_INIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .psc_wr_en   (psc_wr_en),
        .psc_wr_data (psc_wr_data),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_data (arr_wr_data),
        .upd         (upd_evt),
        .ratio       (ratio),
        .reload      (reload)
    );

    tmr_psc_div #(
        .PW (PW)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .restart (sw_upd),
        .ratio   (ratio),
        .tick    (tick)
    );

    tmr_psc_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clear  (sw_upd),
        .reload (reload),
        .cnt    (cnt_val),
        .ovf    (ovf)
    );

    // Update event: natural overflow or software request
    assign upd_evt = ovf | sw_upd;

endmodule

// File: rtl/tmr_psc_chk.sv
module tmr_psc_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en,
    input logic          sw_upd,
    input logic          tick,
    input logic          upd_evt,
    input logic [CW-1:0] cnt_val
);

    localparam logic [CW-1:0] ONE = CW'(1);

    p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_en && !sw_upd));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !sw_upd) |=> $stable(cnt_val));

    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !upd_evt) |=> (cnt_val == $past(cnt_val) + ONE));

    p_update_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> (cnt_val == '0));

    p_overflow_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !sw_upd) |-> tick);

    p_sw_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |-> (upd_evt && !tick));

endmodule

bind tmr_psc_top tmr_psc_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .sw_upd  (sw_upd),
    .tick    (tick),
    .upd_evt (upd_evt),
    .cnt_val (cnt_val)
);

// File: tb/tmr_psc_top_test.sv
module tmr_psc_top_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psc_wr_en = 1'b0;
    logic [15:0] psc_wr_data = '0;
    logic        arr_wr_en = 1'b0;
    logic [15:0] arr_wr_data = '0;
    logic        cnt_en = 1'b0;
    logic        sw_upd = 1'b0;
    logic        tick;
    logic [15:0] cnt_val;
    logic        upd_evt;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    int s_tick, s_cnt, s_upd;

    tmr_psc_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .psc_wr_en   (psc_wr_en),
        .psc_wr_data (psc_wr_data),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_data (arr_wr_data),
        .cnt_en      (cnt_en),
        .sw_upd      (sw_upd),
        .tick        (tick),
        .cnt_val     (cnt_val),
        .upd_evt     (upd_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle after a falling edge, sample outputs before the next rising edge
    task automatic cyc(input bit en, input bit pw, input int pv,
                       input bit aw, input int av, input bit su);
        @(negedge clk);
        cnt_en      = en;
        psc_wr_en   = pw;
        psc_wr_data = pv[15:0];
        arr_wr_en   = aw;
        arr_wr_data = av[15:0];
        sw_upd      = su;
        #1;
        s_tick = int'(tick);
        s_cnt  = int'(cnt_val);
        s_upd  = int'(upd_evt);
    endtask

    task automatic run(input bit en);
        cyc(en, 1'b0, 0, 1'b0, 0, 1'b0);
    endtask

    // Program ratio and reload, then force an update to load them
    task automatic setup(input int n, input int a);
        cyc(1'b0, 1'b1, n, 1'b1, a, 1'b0);
        cyc(1'b0, 1'b0, 0, 1'b0, 0, 1'b1);
        chk("R7", "upd_evt during request", s_upd, 1);
        chk("R7", "tick during request", s_tick, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int nt;
        int last;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        run(1'b0);
        chk("R1", "tick after reset", s_tick, 0);
        chk("R1", "cnt after reset", s_cnt, 0);
        chk("R1", "upd after reset", s_upd, 0);
        for (int k = 0; k < 4; k++) begin
            run(1'b1);
            chk("R1", "tick every cycle", s_tick, 1);
            chk("R1", "cnt counts", s_cnt, k);
            chk("R1", "no update", s_upd, 0);
        end

        // R2 R4 R6: sweep ratios and reload values
        for (int n = 0; n <= 5; n++) begin
            for (int a = 0; a <= 2; a++) begin
                setup(n, a);
                for (int k = 0; k < 3*(n+1)*(a+1); k++) begin
                    int et, ec;
                    run(1'b1);
                    et = ((k % (n+1)) == n) ? 1 : 0;
                    ec = (k / (n+1)) % (a+1);
                    chk("R2", "tick phase", s_tick, et);
                    chk("R4", "cnt value", s_cnt, ec);
                    chk("R4", "update on wrap", s_upd, (et == 1 && ec == a) ? 1 : 0);
                end
            end
        end

        // R5 R6: ratio written mid-period applies after the overflow
        setup(2, 1);
        for (int k = 0; k < 26; k++) begin
            int et, ec, j;
            if (k == 1) cyc(1'b1, 1'b1, 4, 1'b0, 0, 1'b0);
            else        run(1'b1);
            if (k <= 5) begin
                et = ((k % 3) == 2) ? 1 : 0;
                ec = (k / 3) % 2;
                chk("R5", "old ratio kept", s_tick, et);
            end else begin
                j  = k - 6;
                et = ((j % 5) == 4) ? 1 : 0;
                ec = (j / 5) % 2;
                chk("R6", "new ratio from zero", s_tick, et);
            end
            chk("R6", "cnt across change", s_cnt, ec);
        end

        // R3: hold while disabled
        setup(3, 7);
        for (int k = 0; k < 6; k++) run(1'b1);
        chk("R3", "cnt before hold", s_cnt, 1);
        for (int k = 0; k < 5; k++) begin
            run(1'b0);
            chk("R3", "no tick disabled", s_tick, 0);
            chk("R3", "cnt held", s_cnt, 1);
        end
        run(1'b1);
        chk("R3", "resume position 2", s_tick, 0);
        run(1'b1);
        chk("R3", "resume position 3 ticks", s_tick, 1);
        run(1'b1);
        chk("R3", "cnt after resume", s_cnt, 2);

        // R7: request while enabled suppresses tick and clears
        setup(0, 100);
        for (int k = 0; k < 5; k++) run(1'b1);
        chk("R7", "cnt before request", s_cnt, 4);
        cyc(1'b1, 1'b0, 0, 1'b0, 0, 1'b1);
        chk("R7", "tick low on request", s_tick, 0);
        chk("R7", "upd high on request", s_upd, 1);
        run(1'b1);
        chk("R7", "cnt cleared", s_cnt, 0);

        // R9: write in the same cycle as an update
        setup(1, 1000);
        cyc(1'b0, 1'b1, 5, 1'b0, 0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            run(1'b1);
            chk("R9", "previous preload used", s_tick, (k % 2 == 1) ? 1 : 0);
        end
        cyc(1'b0, 1'b0, 0, 1'b0, 0, 1'b1);
        for (int k = 0; k < 12; k++) begin
            run(1'b1);
            chk("R9", "written value at next update", s_tick, (k % 6 == 5) ? 1 : 0);
        end

        // R8: reload write takes effect next cycle
        setup(0, 9);
        for (int k = 0; k < 3; k++) run(1'b1);
        cyc(1'b1, 1'b0, 0, 1'b1, 4, 1'b0);
        chk("R8", "cnt at write", s_cnt, 3);
        chk("R8", "old compare at write", s_upd, 0);
        run(1'b1);
        chk("R8", "cnt at new reload", s_cnt, 4);
        chk("R8", "update at new reload", s_upd, 1);
        run(1'b1);
        chk("R8", "wrapped", s_cnt, 0);

        // R2: largest ratio
        setup(65535, 100);
        nt = 0;
        last = -1;
        for (int k = 0; k < 65536; k++) begin
            run(1'b1);
            if (s_tick == 1) begin
                nt++;
                last = k;
            end
        end
        chk("R2", "one tick at max ratio", nt, 1);
        chk("R2", "tick position at max ratio", last, 65535);
        run(1'b1);
        chk("R2", "cnt after max period", s_cnt, 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule